// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small integer core that executes a subset of the 32-bit RISC-V base instruction set: register-register ALU operations, register-immediate ALU operations, word load, word store and load-upper-immediate. Five stages run in order: fetch, decode, execute, memory and writeback. Four stage registers separate them, and the program counter acts as the register in front of fetch. The stage registers and the PC update on the rising clock edge. The register file and the shared word memory are clocked on the falling edge. As a result, a writeback lands before the decode stage samples its operands in the same cycle, and a load returns its data before the next rising edge.

The core has no hazard detection and no forwarding. Software must place at least two independent instructions, or bubbles, between an instruction that writes a register and the next instruction that reads it. Control signals are decoded once and then travel with the instruction through the stage registers, together with its PC.

A load port fills the memory while reset is held, and a retire port reports every instruction that completes. A small run-control state machine tracks pipeline fill. It starts in HOLD while reset is asserted. It moves HOLD to FILL on the first rising edge after reset, and stays in FILL while the stage registers fill. It moves FILL to FLOW on the fourth rising edge and stays in FLOW until reset.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, the PC is 0, every stage register is cleared, `ret_valid` is 0 and `pipe_full` is 0.
- R2: When `ld_en` is high, `ld_data` is written to word `ld_addr` of the shared memory on the falling edge. Instruction fetch reads word PC[11:2] of the same memory.
- R3: Once reset is released, the PC advances by 4 on every rising edge.
- R4: Count rising edges from the first one after reset release as edge 1. The instruction at byte address 4k appears on the retire port after edge 4+k, so retirements occur on consecutive cycles. `pipe_full` is 0 after edge 3 and 1 from edge 4 onward.
- R5: Opcode 0110011 performs a register-register operation selected by funct3 and bit 30. The encodings are: 000 add (bit 30 = 1 for subtract), 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 logical right shift (bit 30 = 1 for arithmetic right shift), 110 or, 111 and. Shift amounts use operand bits [4:0].
- R6: Opcode 0010011 performs the same operations with the sign-extended immediate in bits [31:20] as the second operand. There is no subtract. The shift amount is immediate bits [4:0], and bit 30 selects arithmetic right shift for funct3 101.
- R7: Opcode 0110111 writes {instr[31:12], 12'b0} to rd.
- R8: With funct3 010, opcode 0100011 stores rs2 to word (rs1 + S-immediate)[11:2]. For a store, `ret_wen` is 0 and `ret_value` is the byte address. With funct3 010, opcode 0000011 loads that word into rd.
- R9: An instruction placed three slots after the instruction that writes its source register reads the new value.
- R10: Register x0 always reads as zero, and writes to it are discarded.
- R11: An all-zero word, any other opcode, or a load or store whose funct3 is not 010 is a bubble. It writes no register and no memory, and it never appears on the retire port.
- R12: For each completed instruction, the retire port shows `ret_valid`, its PC, rd, the register-write enable, and the value written. For a load this value is the loaded word. Retirements come out in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stage registers on rising edge, register file and memory on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Memory load strobe |
| ld_addr | input | MEM_AW | Word address for loading |
| ld_data | input | 32 | Word to load |
| ret_valid | output | 1 | An instruction completed this cycle |
| ret_pc | output | 32 | PC of the completed instruction |
| ret_rd | output | 5 | Destination register index |
| ret_wen | output | 1 | Register write enable of the completed instruction |
| ret_value | output | 32 | Writeback value, or store address for stores |
| pipe_full | output | 1 | Run-control state machine is in FLOW |

## Verification
The hardest behaviour to reach from the ports is the same-cycle hand-off: a falling-edge register write must reach a reader that is exactly three slots behind the writer. The same applies to a store followed later by a load of the same word. The bench builds programs in which every instruction is followed by two all-zero bubbles, so every dependency sits at that minimum distance. Each run reloads memory and sweeps every ALU operation over six corner operands, including the sign boundary and a low half of 0x800 or above, which needs the upper-immediate adjustment. A tight run of independent instructions, together with a cycle stamp on every retirement, checks the fill latency and the one-per-cycle throughput.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;
    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [2:0] F3_WORD   = 3'b010;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {RUN_HOLD, RUN_FILL, RUN_FLOW} run_state_e;

    typedef struct packed {
        logic    valid;
        logic    reg_we;
        logic    mem_we;
        logic    mem_re;
        logic    use_imm;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] instr;
    } ifid_t;

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        ctrl_t             ctrl;
        logic [XLEN-1:0]   rs1v;
        logic [XLEN-1:0]   rs2v;
        logic [XLEN-1:0]   imm;
        logic [REG_AW-1:0] rd;
    } idex_t;

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic              valid;
        logic              reg_we;
        logic              mem_we;
        logic              mem_re;
        logic [XLEN-1:0]   alu;
        logic [XLEN-1:0]   store;
        logic [REG_AW-1:0] rd;
    } exmem_t;

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic              valid;
        logic              reg_we;
        logic              from_mem;
        logic [XLEN-1:0]   alu;
        logic [XLEN-1:0]   load;
        logic [REG_AW-1:0] rd;
    } memwb_t;

    function automatic logic [XLEN-1:0] alu_eval(alu_op_e op, logic [XLEN-1:0] a,
                                                 logic [XLEN-1:0] b);
        logic [4:0] sh;
        sh = b[4:0];
        unique case (op)
            ALU_ADD:   return a + b;
            ALU_SUB:   return a - b;
            ALU_SLL:   return a << sh;
            ALU_SLT:   return {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_SLTU:  return {{(XLEN-1){1'b0}}, a < b};
            ALU_XOR:   return a ^ b;
            ALU_SRL:   return a >> sh;
            ALU_SRA:   return $unsigned($signed(a) >>> sh);
            ALU_OR:    return a | b;
            ALU_AND:   return a & b;
            ALU_PASSB: return b;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/pipe5_stage.sv
`timescale 1ns/1ps
module pipe5_stage #(
    parameter type T = logic
) (
    input  logic clk,
    input  logic rst_n,
    input  T     q_in,
    output T     q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_in;
    end
endmodule

// File: rtl/pipe5_decode.sv
`timescale 1ns/1ps
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output ctrl_t             ctrl,
    output logic [XLEN-1:0]   imm,
    output logic [REG_AW-1:0] rs1,
    output logic [REG_AW-1:0] rs2,
    output logic [REG_AW-1:0] rd
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic       alt;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign alt = instr[30];
    assign rd  = instr[11:7];
    assign rs1 = instr[19:15];
    assign rs2 = instr[24:20];

    function automatic alu_op_e pick_op(logic [2:0] fn, logic alt_bit, logic sub_ok);
        unique case (fn)
            3'd0:    return (sub_ok && alt_bit) ? ALU_SUB : ALU_ADD;
            3'd1:    return ALU_SLL;
            3'd2:    return ALU_SLT;
            3'd3:    return ALU_SLTU;
            3'd4:    return ALU_XOR;
            3'd5:    return alt_bit ? ALU_SRA : ALU_SRL;
            3'd6:    return ALU_OR;
            default: return ALU_AND;
        endcase
    endfunction

    always_comb begin
        ctrl = '0;
        imm  = '0;
        unique case (opc)
            OPC_REG: begin
                ctrl.valid  = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = pick_op(f3, alt, 1'b1);
            end
            OPC_IMM: begin
                ctrl.valid   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = pick_op(f3, alt, 1'b0);
                imm          = {{20{instr[31]}}, instr[31:20]};
            end
            OPC_LOAD: begin
                if (f3 == F3_WORD) begin
                    ctrl.valid   = 1'b1;
                    ctrl.reg_we  = 1'b1;
                    ctrl.mem_re  = 1'b1;
                    ctrl.use_imm = 1'b1;
                    ctrl.alu_op  = ALU_ADD;
                    imm          = {{20{instr[31]}}, instr[31:20]};
                end
            end
            OPC_STORE: begin
                if (f3 == F3_WORD) begin
                    ctrl.valid   = 1'b1;
                    ctrl.mem_we  = 1'b1;
                    ctrl.use_imm = 1'b1;
                    ctrl.alu_op  = ALU_ADD;
                    imm          = {{20{instr[31]}}, instr[31:25], instr[11:7]};
                end
            end
            OPC_LUI: begin
                ctrl.valid   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_PASSB;
                imm          = {instr[31:12], 12'b0};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pipe5_regfile.sv
`timescale 1ns/1ps
module pipe5_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs [NREG];

    // Falling-edge write: lands before the next rising edge samples ID.
    always_ff @(negedge clk) begin
        if (we && (wa != '0)) regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/pipe5_mem.sv
`timescale 1ns/1ps
module pipe5_mem #(
    parameter int AW    = 10,
    parameter int W     = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_data,
    input  logic [AW-1:0] i_addr,
    output logic [W-1:0]  i_q,
    input  logic [AW-1:0] d_addr,
    input  logic          d_we,
    input  logic [W-1:0]  d_wdata,
    output logic [W-1:0]  d_q
);
    logic [W-1:0] words [DEPTH];

    always_ff @(negedge clk) begin
        if (ld_en)     words[ld_addr] <= ld_data;
        else if (d_we) words[d_addr]  <= d_wdata;
        i_q <= words[i_addr];
        d_q <= words[d_addr];
    end
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int MEM_AW = 10,
    parameter int NREG   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic              ret_valid,
    output logic [XLEN-1:0]   ret_pc,
    output logic [REG_AW-1:0] ret_rd,
    output logic              ret_wen,
    output logic [XLEN-1:0]   ret_value,
    output logic              pipe_full
);
    localparam int FILL_EDGES = 4;
    localparam int FILL_W     = $clog2(FILL_EDGES + 1);

    logic [XLEN-1:0] pc_q;
    ifid_t  ifid_d,  ifid_q;
    idex_t  idex_d,  idex_q;
    exmem_t exmem_d, exmem_q;
    memwb_t memwb_d, memwb_q;

    logic [XLEN-1:0]   i_word, d_word;
    ctrl_t             dec_ctrl;
    logic [XLEN-1:0]   dec_imm, rf_a, rf_b, alu_b, wb_data;
    logic [REG_AW-1:0] dec_rs1, dec_rs2, dec_rd;

    // ---------------- run control ----------------
    run_state_e        st_q, st_d;
    logic [FILL_W-1:0] fill_q, fill_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RUN_HOLD;
            fill_q <= '0;
        end else begin
            st_q   <= st_d;
            fill_q <= fill_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        fill_d = fill_q;
        unique case (st_q)
            RUN_HOLD: begin
                st_d   = RUN_FILL;
                fill_d = FILL_W'(1);
            end
            RUN_FILL: begin
                if (fill_q == FILL_W'(FILL_EDGES - 1)) st_d = RUN_FLOW;
                else fill_d = fill_q + FILL_W'(1);
            end
            RUN_FLOW: st_d = RUN_FLOW;
            default:  st_d = RUN_HOLD;
        endcase
    end

    always_comb begin
        pipe_full = (st_q == RUN_FLOW);
    end

    // ---------------- IF ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + XLEN'(4);
    end

    pipe5_mem #(.AW(MEM_AW), .W(XLEN)) u_mem (
        .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .i_addr(pc_q[MEM_AW+1:2]), .i_q(i_word),
        .d_addr(exmem_q.alu[MEM_AW+1:2]), .d_we(exmem_q.mem_we),
        .d_wdata(exmem_q.store), .d_q(d_word)
    );

    always_comb begin
        ifid_d.pc    = pc_q;
        ifid_d.instr = i_word;
    end

    pipe5_stage #(.T(ifid_t)) u_if_id (.clk(clk), .rst_n(rst_n), .q_in(ifid_d), .q(ifid_q));

    // ---------------- ID ----------------
    pipe5_decode u_dec (
        .instr(ifid_q.instr), .ctrl(dec_ctrl), .imm(dec_imm),
        .rs1(dec_rs1), .rs2(dec_rs2), .rd(dec_rd)
    );

    pipe5_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk(clk), .we(memwb_q.reg_we), .wa(memwb_q.rd), .wd(wb_data),
        .ra1(dec_rs1), .ra2(dec_rs2), .rd1(rf_a), .rd2(rf_b)
    );

    always_comb begin
        idex_d.pc   = ifid_q.pc;
        idex_d.ctrl = dec_ctrl;
        idex_d.rs1v = rf_a;
        idex_d.rs2v = rf_b;
        idex_d.imm  = dec_imm;
        idex_d.rd   = dec_rd;
    end

    pipe5_stage #(.T(idex_t)) u_id_ex (.clk(clk), .rst_n(rst_n), .q_in(idex_d), .q(idex_q));

    // ---------------- EX ----------------
    assign alu_b = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.rs2v;

    always_comb begin
        exmem_d.pc     = idex_q.pc;
        exmem_d.valid  = idex_q.ctrl.valid;
        exmem_d.reg_we = idex_q.ctrl.reg_we;
        exmem_d.mem_we = idex_q.ctrl.mem_we;
        exmem_d.mem_re = idex_q.ctrl.mem_re;
        exmem_d.alu    = alu_eval(idex_q.ctrl.alu_op, idex_q.rs1v, alu_b);
        exmem_d.store  = idex_q.rs2v;
        exmem_d.rd     = idex_q.rd;
    end

    pipe5_stage #(.T(exmem_t)) u_ex_mem (.clk(clk), .rst_n(rst_n), .q_in(exmem_d), .q(exmem_q));

    // ---------------- MEM ----------------
    always_comb begin
        memwb_d.pc       = exmem_q.pc;
        memwb_d.valid    = exmem_q.valid;
        memwb_d.reg_we   = exmem_q.reg_we;
        memwb_d.from_mem = exmem_q.mem_re;
        memwb_d.alu      = exmem_q.alu;
        memwb_d.load     = d_word;
        memwb_d.rd       = exmem_q.rd;
    end

    pipe5_stage #(.T(memwb_t)) u_mem_wb (.clk(clk), .rst_n(rst_n), .q_in(memwb_d), .q(memwb_q));

    // ---------------- WB ----------------
    assign wb_data   = memwb_q.from_mem ? memwb_q.load : memwb_q.alu;
    assign ret_valid = memwb_q.valid;
    assign ret_pc    = memwb_q.pc;
    assign ret_rd    = memwb_q.rd;
    assign ret_wen   = memwb_q.reg_we;
    assign ret_value = wb_data;

    // R4
    retire_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> pipe_full);

    // R12
    retire_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && $past(ret_valid)) |-> (ret_pc == $past(ret_pc) + XLEN'(4)));

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pc_q == $past(pc_q) + XLEN'(4)));

    // R11
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_q.ctrl.valid |-> (!idex_q.ctrl.reg_we && !idex_q.ctrl.mem_we));

    // R8
    store_no_regwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_q.valid && exmem_q.mem_we) |=> (ret_valid && !ret_wen));
endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_en;
    logic [9:0]  ld_addr;
    logic [31:0] ld_data;
    logic        ret_valid, ret_wen, pipe_full;
    logic [31:0] ret_pc, ret_value;
    logic [4:0]  ret_rd;

    always #2.5 clk = ~clk;

    pipe5_core u_pipe5_core (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_rd(ret_rd), .ret_wen(ret_wen),
        .ret_value(ret_value), .pipe_full(pipe_full)
    );

    int nchk = 0;
    int nfail = 0;

    logic [31:0] prog [1024];
    logic [31:0] mmem [1024];
    logic [31:0] mreg [32];
    logic [31:0] e_pc  [1024];
    logic [4:0]  e_rd  [1024];
    logic        e_wen [1024];
    logic [31:0] e_val [1024];
    string       e_tag [1024];
    int np, ne;

    logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h1234_5A7C};

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_op(logic [2:0] f3, logic alt, logic [31:0] a,
                                           logic [31:0] b);
        case (f3)
            3'd0: return alt ? a - b : a + b;
            3'd1: return a << b[4:0];
            3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd3: return (a < b) ? 32'd1 : 32'd0;
            3'd4: return a ^ b;
            3'd5: return alt ? $unsigned($signed(a) >>> b[4:0]) : a >> b[4:0];
            3'd6: return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic logic [31:0] e_r(logic [2:0] f3, logic alt, int rd, int rs1, int rs2);
        return {1'b0, alt, 5'b0, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
    endfunction
    function automatic logic [31:0] e_i(logic [11:0] imm, int rs1, logic [2:0] f3, int rd);
        return {imm, 5'(rs1), f3, 5'(rd), 7'b0010011};
    endfunction
    function automatic logic [31:0] e_lw(logic [11:0] imm, int rs1, int rd);
        return {imm, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
    endfunction
    function automatic logic [31:0] e_sw(logic [11:0] imm, int rs2, int rs1);
        return {imm[11:5], 5'(rs2), 5'(rs1), 3'b010, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] e_lui(logic [19:0] up, int rd);
        return {up, 5'(rd), 7'b0110111};
    endfunction

    task automatic model(input logic [31:0] w, input string tag);
        logic [31:0] a, b, val, adr, immi, imms;
        logic wen, ok;
        a    = mreg[w[19:15]];
        b    = mreg[w[24:20]];
        immi = {{20{w[31]}}, w[31:20]};
        imms = {{20{w[31]}}, w[31:25], w[11:7]};
        ok = 1'b1; wen = 1'b1; val = '0;
        case (w[6:0])
            7'b0110011: val = ref_op(w[14:12], w[30], a, b);
            7'b0010011: val = ref_op(w[14:12], (w[14:12] == 3'd5) && w[30], a, immi);
            7'b0110111: val = {w[31:12], 12'b0};
            7'b0000011: begin
                ok = (w[14:12] == 3'b010);
                adr = a + immi;
                val = mmem[adr[11:2]];
            end
            7'b0100011: begin
                ok = (w[14:12] == 3'b010);
                adr = a + imms;
                wen = 1'b0;
                val = adr;
                if (ok) mmem[adr[11:2]] = b;
            end
            default: ok = 1'b0;
        endcase
        if (ok) begin
            if (wen && w[11:7] != 5'd0) mreg[w[11:7]] = val;
            e_pc[ne] = 32'(np * 4); e_rd[ne] = w[11:7]; e_wen[ne] = wen;
            e_val[ne] = val; e_tag[ne] = tag;
            ne++;
        end
    endtask

    task automatic emit_raw(input logic [31:0] w, input string tag);
        model(w, tag);
        prog[np] = w;
        np++;
    endtask

    task automatic emit(input logic [31:0] w, input string tag);
        emit_raw(w, tag);
        emit_raw(32'h0, "R11");
        emit_raw(32'h0, "R11");
    endtask

    task automatic set_reg(input int r, input logic [31:0] v);
        logic [31:0] up;
        up = (v + 32'h800) >> 12;
        emit(e_lui(up[19:0], r), "R7");
        emit(e_i(v[11:0], r, 3'd0, r), "R9");
    endtask

    task automatic new_prog();
        for (int i = 0; i < 1024; i++) begin
            prog[i] = '0;
            mmem[i] = '0;
        end
        mreg[0] = '0;
        np = 0; ne = 0;
        for (int i = 0; i < 6; i++) set_reg(1 + i, vals[i]);
    endtask

    task automatic run_prog();
        int cyc, got;
        rst_n = 1'b0;
        @(posedge clk);
        for (int a = 0; a < 1024; a++) begin
            ld_en = 1'b1; ld_addr = 10'(a); ld_data = prog[a];
            @(posedge clk);
        end
        ld_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!ret_valid && !pipe_full, "R1 reset quiet", {62'b0, ret_valid, pipe_full}, 64'h0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        cyc = 0; got = 0;
        repeat (np + 8) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 3) chk(!pipe_full, "R4 fill not done", 64'(pipe_full), 64'h0);
            if (cyc == 4) chk(pipe_full, "R4 fill done", 64'(pipe_full), 64'h1);
            if (ret_valid) begin
                if (got >= ne) begin
                    chk(1'b0, "R11 unexpected retire", 64'(ret_pc), 64'hFFFF_FFFF);
                end else begin
                    // R4 / R12: program order and cycle of retirement (loader R2 feeds fetch)
                    chk(ret_pc == e_pc[got] && cyc == 4 + int'(e_pc[got] >> 2),
                        "R4 R12 retire pc/cycle", {ret_pc, 32'(cyc)},
                        {e_pc[got], 32'(4 + int'(e_pc[got] >> 2))});
                    chk(ret_rd == e_rd[got] && ret_wen == e_wen[got] && ret_value == e_val[got],
                        e_tag[got], {26'b0, ret_rd, ret_wen, ret_value},
                        {26'b0, e_rd[got], e_wen[got], e_val[got]});
                end
                got++;
            end
        end
        chk(got == ne, "R12 R11 retire count", 64'(got), 64'(ne));
        rst_n = 1'b0;
    endtask

    function automatic logic [3:0] r_sel(int k);
        case (k)
            0: return 4'b0000; 1: return 4'b0001; 2: return 4'b0010; 3: return 4'b0100;
            4: return 4'b0110; 5: return 4'b1000; 6: return 4'b1010; 7: return 4'b1011;
            8: return 4'b1100; default: return 4'b1110;
        endcase
    endfunction

    logic [11:0] imms_plain [6] = '{12'h000, 12'h001, 12'hFFF, 12'h7FF, 12'h800, 12'h123};
    logic [4:0]  shamts     [6] = '{5'd0, 5'd1, 5'd31, 5'd7, 5'd16, 5'd3};

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                nchk++; nfail++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", nchk - nfail, nchk);
                $finish;
            end
        end
    end

    initial begin
        logic [3:0] s;
        rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        for (int i = 0; i < 32; i++) mreg[i] = '0;

        // R5: every register-register operation over all operand pairs
        for (int k = 0; k < 10; k++) begin
            new_prog();
            s = r_sel(k);
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    emit(e_r(s[3:1], s[0], 7 + ((i * 6 + j) % 24), 1 + i, 1 + j), "R5");
            run_prog();
        end

        // R6: every immediate operation over all operands and immediates
        for (int k = 0; k < 9; k++) begin
            logic [2:0] f3;
            logic       alt;
            new_prog();
            f3  = (k < 6) ? 3'(k == 0 ? 0 : (k == 1 ? 2 : (k == 2 ? 3 : (k == 3 ? 4 : (k == 4 ? 6 : 7)))))
                          : ((k == 6) ? 3'd1 : 3'd5);
            alt = (k == 8);
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++) begin
                    logic [11:0] im;
                    im = (k < 6) ? imms_plain[j] : {1'b0, alt, 5'b0, shamts[j]};
                    emit(e_i(im, 1 + i, f3, 7 + ((i * 6 + j) % 24)), "R6");
                end
            run_prog();
        end

        // R7 R8 R9 R10 R11 and tight issue
        new_prog();
        emit(e_lui(20'hABCDE, 20), "R7");
        emit(e_lui(20'h80000, 21), "R7");
        set_reg(7, 32'd3600);
        for (int i = 0; i < 6; i++) emit(e_sw(12'(-16 + 4 * i), 1 + i, 7), "R8");
        for (int i = 0; i < 6; i++) emit(e_lw(12'(-16 + 4 * i), 7, 10 + i), "R8");
        emit(e_sw(12'd0, 2, 7), "R8");
        emit(e_lw(12'd0, 7, 16), "R8");
        emit(e_r(3'd0, 1'b0, 0, 1, 3), "R10");
        emit(e_r(3'd0, 1'b0, 17, 0, 0), "R10");
        set_reg(9, 32'd77);
        emit({20'h0, 5'd9, 7'h7F}, "R11");
        emit(e_lw(12'd0, 0, 9) & ~32'h0000_7000, "R11");
        emit({7'h0, 5'd1, 5'd0, 3'b000, 5'b0, 7'b0100011}, "R11");
        emit(e_r(3'd0, 1'b0, 18, 9, 0), "R11");
        emit_raw(e_i(12'd100, 0, 3'd0, 28), "R9");
        emit_raw(32'h0, "R11");
        emit_raw(32'h0, "R11");
        emit_raw(e_i(12'd5, 28, 3'd0, 29), "R9");
        for (int i = 0; i < 6; i++) emit_raw(e_i(12'(i + 40), 0, 3'd0, 22 + i), "R4");
        emit(32'h0, "R11");
        run_prog();

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule